// File: doc/BRIEF.md
# Sample-Serial IIR Lattice-Ladder Filter

This block is an all-pole lattice filter followed by a ladder (tapped) output sum. It works on signed 16-bit fixed-point data with 15 fraction bits. The number of lattice stages is a parameter. Samples arrive one at a time on a valid/ready stream. For each accepted sample a small sequencer steps through the stages, one stage per clock, on a single shared datapath. The datapath has one multiplier pair for the stage recursion and one multiplier pair for the ladder terms. When the last stage is done, one saturated output sample is presented on a second valid/ready stream.

Each stage saturates its forward and backward values to 16 bits. The ladder products are summed at full precision in a wide accumulator. The sum is reduced to the output format only once, at the end of the sample: it is shifted right arithmetically by 15 and then clamped. The delay state is stored in a shadow buffer while the stages run and is replaced as a whole when the sample finishes, so every stage reads the previous sample's state.

The reflection and ladder coefficients are loaded through a plain write port. Writes take effect only while the engine is idle. Back-pressure works as follows: the input side is ready only when the engine is idle, so the stream stalls from the moment a sample is accepted until its result has been taken. The output stays valid, with its data frozen, for as long as the consumer holds ready low.

Top module: `lat_iir`

## Requirements
- R1: A synchronous reset, active high, clears the delay state, all coefficients and the accumulator. After reset `s_ready` is 1 and `m_valid` is 0, and the first sample is processed against an all-zero state.
- R2: Stage m (m = 0 to N-1, in that order) forms f_out = sat16(f_in - ((k[m]*g_d[m]) >>> 15)). Stage 0 takes the input sample as f_in; every later stage takes the previous stage's f_out.
- R3: The same stage forms g_out = sat16(((k[m]*f_out) >>> 15) + g_d[m]), using the already saturated f_out.
- R4: The output is sat16((sum over m of g_out(m)*v[m] + f_out(N-1)*v[N]) >>> 15). The sum is held in a wide accumulator, so intermediate values never wrap. Outputs above 32767 give 32767, and outputs below -32768 give -32768.
- R5: After each sample, the delay word for stage m becomes g_out(m+1) for m < N-1, and the delay word for stage N-1 becomes f_out(N-1). All stages of a sample read the state left by the previous sample.
- R6: An input is accepted on a clock edge where `s_valid` and `s_ready` are both 1. `s_ready` is then 0 until the result has been accepted. `m_valid` rises exactly N cycles after the accepting edge.
- R7: While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and `m_data` does not change. The result is consumed on an edge where both are 1.
- R8: A coefficient write (`cfg_we`=1) is ignored while a sample is in flight, that is, whenever `s_ready` is 0.
- R9: Every right shift is arithmetic and rounds toward negative infinity. For example, an accumulator of -1 gives an output of -1.
- R10: `cfg_ladder`=0 writes reflection coefficient k[`cfg_addr`] for addresses 0..N-1. `cfg_ladder`=1 writes ladder coefficient v[`cfg_addr`] for addresses 0..N. Writes to higher addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Engine idle, input can be accepted |
| s_data | input | DW | Input sample, signed Q1.15 |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Consumer takes output |
| m_data | output | DW | Output sample, signed Q1.15 |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_ladder | input | 1 | 0 selects reflection bank, 1 selects ladder bank |
| cfg_addr | input | AW | Coefficient index, AW = clog2(N+1) |
| cfg_data | input | DW | Coefficient value, signed Q1.15 |

## Verification
Some properties are checked by the assertions on every cycle. These are the handshake rules: input ready drops after an acceptance, no input is taken while a result is pending, and the output holds its valid and its data under back-pressure. The assertions also check the fixed N-cycle latency and the idle state right after reset. The arithmetic cannot be checked that way: stage saturation, the single final truncation, the floor rounding of negative values, the state hand-over between samples and the rejection of coefficient writes during a run. Only the bench scenarios show these, by comparing outputs against an independent sample-by-sample model.

// File: rtl/lat_iir_pkg.sv
package lat_iir_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_OUT  = 2'd2
  } seq_state_t;

  // Clamp a signed value into the signed range of w bits.
  function automatic logic signed [63:0] clamp_w(input logic signed [63:0] val,
                                                  input int unsigned w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (val > hi)      return hi;
    else if (val < lo) return lo;
    else               return val;
  endfunction

endpackage

// File: rtl/lat_stage_math.sv
// One lattice section: forward update, then backward update from the
// saturated forward value. Purely combinational.
module lat_stage_math #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] f_in,
  input  logic signed [DW-1:0] g_dly,
  input  logic signed [DW-1:0] kref,
  output logic signed [DW-1:0] f_out,
  output logic signed [DW-1:0] g_out
);
  import lat_iir_pkg::*;

  localparam int FRAC = DW - 1;
  localparam int PW   = 2 * DW;
  localparam int EW   = PW + 2;

  logic signed [PW-1:0] prod_kg;
  logic signed [PW-1:0] prod_kf;
  logic signed [EW-1:0] f_wide;
  logic signed [EW-1:0] g_wide;

  always_comb begin
    prod_kg = kref * g_dly;
    f_wide  = EW'(f_in) - EW'(prod_kg >>> FRAC);
    f_out   = DW'(clamp_w(64'(f_wide), DW));
    prod_kf = kref * f_out;
    g_wide  = EW'(prod_kf >>> FRAC) + EW'(g_dly);
    g_out   = DW'(clamp_w(64'(g_wide), DW));
  end

endmodule

// File: rtl/lat_coef_bank.sv
// Reflection and ladder coefficient registers with indexed read.
module lat_coef_bank #(
  parameter int NSTG = 4,
  parameter int DW   = 16,
  parameter int AW   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 wr_ladder,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [DW-1:0] wr_data,
  input  logic [AW-1:0]        rd_idx,
  output logic signed [DW-1:0] k_rd,
  output logic signed [DW-1:0] v_rd,
  output logic signed [DW-1:0] v_tail
);
  localparam int DEPTH = 1 << AW;

  logic signed [DW-1:0] k_mem [DEPTH];
  logic signed [DW-1:0] v_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        k_mem[i] <= '0;
        v_mem[i] <= '0;
      end
    end else if (wr_en) begin
      if (!wr_ladder && (32'(wr_addr) < NSTG))
        k_mem[wr_addr] <= wr_data;
      if (wr_ladder && (32'(wr_addr) <= NSTG))
        v_mem[wr_addr] <= wr_data;
    end
  end

  assign k_rd   = k_mem[rd_idx];
  assign v_rd   = v_mem[rd_idx];
  assign v_tail = v_mem[NSTG];

endmodule

// File: rtl/lat_delay_line.sv
// Delay state plus a shadow buffer. New backward values collect in the
// shadow while a sample runs; the visible state is replaced on commit.
module lat_delay_line #(
  parameter int NSTG = 4,
  parameter int DW   = 16,
  parameter int AW   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        rd_idx,
  output logic signed [DW-1:0] rd_val,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_idx,
  input  logic signed [DW-1:0] wr_val,
  input  logic                 commit,
  input  logic signed [DW-1:0] last_g,
  input  logic signed [DW-1:0] last_f
);
  localparam int DEPTH = 1 << AW;

  logic signed [DW-1:0] dly  [DEPTH];
  logic signed [DW-1:0] shad [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        dly[i]  <= '0;
        shad[i] <= '0;
      end
    end else begin
      if (wr_en)
        shad[wr_idx] <= wr_val;
      if (commit) begin
        for (int m = 0; m < NSTG; m++) begin
          if (m == NSTG - 1)
            dly[m] <= last_f;
          else if (m == NSTG - 2)
            dly[m] <= last_g;
          else
            dly[m] <= shad[m + 1];
        end
      end
    end
  end

  assign rd_val = dly[rd_idx];

endmodule

// File: rtl/lat_iir.sv
module lat_iir #(
  parameter int NSTG  = 4,
  parameter int DW    = 16,
  parameter int ACC_W = 64,
  parameter int AW    = $clog2(NSTG + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  input  logic          cfg_we,
  input  logic          cfg_ladder,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_data
);
  import lat_iir_pkg::*;

  localparam int FRAC = DW - 1;
  localparam int PW   = 2 * DW;
  localparam logic [AW-1:0] LAST_IDX = AW'(NSTG - 1);

  seq_state_t           state_q;
  logic [AW-1:0]        idx_q;
  logic signed [DW-1:0] f_q;
  logic signed [ACC_W-1:0] acc_q;
  logic [DW-1:0]        out_q;
  logic                 mval_q;

  logic signed [DW-1:0] k_rd, v_rd, v_tail, g_dly;
  logic signed [DW-1:0] f_out, g_out;
  logic signed [PW-1:0] prod_gv, prod_fv;
  logic signed [ACC_W-1:0] acc_nxt, acc_fin, acc_shr;
  logic signed [DW-1:0] y_sat;
  logic                 running, last_stage, idle;

  assign idle       = (state_q == SEQ_IDLE);
  assign running    = (state_q == SEQ_RUN);
  assign last_stage = (idx_q == LAST_IDX);

  lat_coef_bank #(.NSTG(NSTG), .DW(DW), .AW(AW)) u_coef (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_we && idle),
    .wr_ladder (cfg_ladder),
    .wr_addr   (cfg_addr),
    .wr_data   (cfg_data),
    .rd_idx    (idx_q),
    .k_rd      (k_rd),
    .v_rd      (v_rd),
    .v_tail    (v_tail)
  );

  lat_delay_line #(.NSTG(NSTG), .DW(DW), .AW(AW)) u_dly (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (idx_q),
    .rd_val (g_dly),
    .wr_en  (running),
    .wr_idx (idx_q),
    .wr_val (g_out),
    .commit (running && last_stage),
    .last_g (g_out),
    .last_f (f_out)
  );

  lat_stage_math #(.DW(DW)) u_stage (
    .f_in  (f_q),
    .g_dly (g_dly),
    .kref  (k_rd),
    .f_out (f_out),
    .g_out (g_out)
  );

  // Ladder sum at full product precision; one reduction at the end.
  always_comb begin
    prod_gv = g_out * v_rd;
    prod_fv = f_out * v_tail;
    acc_nxt = acc_q + ACC_W'(prod_gv);
    acc_fin = acc_nxt + ACC_W'(prod_fv);
    acc_shr = acc_fin >>> FRAC;
    y_sat   = DW'(clamp_w(64'(acc_shr), DW));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      f_q     <= '0;
      acc_q   <= '0;
      out_q   <= '0;
      mval_q  <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (s_valid) begin
            f_q     <= s_data;
            acc_q   <= '0;
            idx_q   <= '0;
            state_q <= SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          f_q   <= f_out;
          acc_q <= acc_nxt;
          idx_q <= idx_q + AW'(1);
          if (last_stage) begin
            out_q   <= y_sat;
            mval_q  <= 1'b1;
            state_q <= SEQ_OUT;
          end
        end
        SEQ_OUT: begin
          if (m_ready) begin
            mval_q  <= 1'b0;
            state_q <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign s_ready = idle;
  assign m_valid = mval_q;
  assign m_data  = out_q;

endmodule

// File: rtl/lat_iir_chk.sv
module lat_iir_chk #(
  parameter int NSTG = 4,
  parameter int DW   = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          s_valid,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic [DW-1:0] m_data
);
  logic        rst_d;
  logic [15:0] lat_cnt;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)
      lat_cnt <= '0;
    else if (s_valid && s_ready)
      lat_cnt <= '0;
    else if (!s_ready && !m_valid)
      lat_cnt <= lat_cnt + 16'd1;
  end

  // R1: idle handshake state right after reset
  always @(posedge clk) begin
    if (rst_d) begin
      p_reset_idle_r1: assert (s_ready && !m_valid)
        else $error("reset did not leave the engine idle");
    end
  end

  p_accept_drops_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  p_pending_blocks_input_r6: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> !s_ready);

  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> (lat_cnt == 16'(NSTG)));

  p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

endmodule

bind lat_iir lat_iir_chk #(.NSTG(NSTG), .DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data)
);

// File: tb/lat_iir_test.sv
`timescale 1ns/1ps
module lat_iir_test;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int AW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_data = '0;
  logic          m_valid;
  logic          m_ready = 1'b0;
  logic [DW-1:0] m_data;
  logic          cfg_we = 1'b0;
  logic          cfg_ladder = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_data = '0;

  int n_chk = 0;
  int n_err = 0;

  longint mk [N];
  longint mv [N+1];
  longint md [N];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #10 clk = ~clk;

  lat_iir #(.NSTG(N), .DW(DW)) uut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .cfg_we(cfg_we),
    .cfg_ladder(cfg_ladder), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  function automatic longint sat16(input longint x);
    if (x > 32767)  return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rnd16(output logic [15:0] r);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    r = lfsr[23:8];
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin mk[i] = 0; md[i] = 0; end
    for (int i = 0; i <= N; i++) mv[i] = 0;
  endtask

  task automatic model_step(input longint x, output longint y);
    longint f, g, acc;
    longint ng [N];
    f = x; acc = 0;
    for (int m = 0; m < N; m++) begin
      f = sat16(f - ((mk[m] * md[m]) >>> 15));
      g = sat16(((mk[m] * f) >>> 15) + md[m]);
      ng[m] = g;
      acc += g * mv[m];
    end
    acc += f * mv[N];
    y = sat16(acc >>> 15);
    for (int m = 0; m < N - 1; m++) md[m] = ng[m + 1];
    md[N-1] = f;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_clear();
  endtask

  task automatic wr_coef(input bit lad, input int addr, input longint val, input bit takes);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ladder = lad; cfg_addr = AW'(addr); cfg_data = DW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (takes) begin
      if (lad) mv[addr] = val; else mk[addr] = val;
    end
  endtask

  task automatic push(input longint x, output longint y);
    int t;
    @(negedge clk);
    s_valid = 1'b1; s_data = DW'(x);
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    t = 0;
    while (!m_valid && t < 200) begin @(negedge clk); t++; end
    y = longint'($signed(m_data));
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
  endtask

  task automatic push_check(input string req, input longint x);
    longint y, e;
    push(x, y);
    model_step(x, e);
    check(req, y, e);
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    check("R1 s_ready after reset", s_ready, 1);
    check("R1 m_valid after reset", m_valid, 0);
  endtask

  task automatic t_passthrough();
    // k all zero, only tail ladder tap: each stage passes f through
    wr_coef(1, N, 16384, 1);
    push_check("R2 passthrough", 1000);
    push_check("R2 passthrough", -2000);
    wr_coef(1, 0, 16384, 1);
    push_check("R5 delay hand-over", 300);
    push_check("R5 delay hand-over", 0);
    push_check("R5 delay hand-over", 0);
  endtask

  task automatic t_random(input int nsamp);
    logic [15:0] r;
    for (int i = 0; i < N; i++) begin rnd16(r); wr_coef(0, i, longint'($signed(r)) >>> 1, 1); end
    for (int i = 0; i <= N; i++) begin rnd16(r); wr_coef(1, i, longint'($signed(r)), 1); end
    for (int s = 0; s < nsamp; s++) begin
      rnd16(r);
      push_check("R4 random stream", longint'($signed(r)));
    end
  endtask

  task automatic t_stage_sat();
    do_reset();
    for (int i = 0; i < N; i++) wr_coef(0, i, -32768, 1);
    for (int i = 0; i <= N; i++) wr_coef(1, i, 12000, 1);
    for (int s = 0; s < 8; s++) push_check("R2 R3 stage saturation", 30000);
    for (int s = 0; s < 4; s++) push_check("R3 stage saturation", -32768);
  endtask

  task automatic t_out_sat();
    longint y, e;
    do_reset();
    for (int i = 0; i <= N; i++) wr_coef(1, i, 32767, 1);
    push_check("R4 first sample", 32767);
    push(32767, y); model_step(32767, e);
    check("R4 positive clamp", y, 32767);
    for (int s = 0; s < N + 1; s++) begin push(-32768, y); model_step(-32768, e); end
    check("R4 negative clamp", y, -32768);
  endtask

  task automatic t_floor();
    longint y, e;
    do_reset();
    wr_coef(1, N, 1, 1);
    push(-1, y); model_step(-1, e);
    check("R9 floor of -1", y, -1);
    push(5, y); model_step(5, e);
    check("R9 floor of positive", y, 0);
  endtask

  task automatic t_backpressure();
    logic [DW-1:0] held;
    int t;
    @(negedge clk);
    s_valid = 1'b1; s_data = 16'd1234;
    @(negedge clk);
    check("R6 ready low after accept", s_ready, 0);
    t = 0;
    while (!m_valid && t < 200) begin @(negedge clk); t++; end
    held = m_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R7 valid held", m_valid, 1);
      check("R7 data held", m_data, held);
      check("R6 no accept while pending", s_ready, 0);
    end
    s_valid = 1'b0;
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
    check("R7 consumed", m_valid, 0);
    begin longint e; model_step(1234, e); check("R7 held value", longint'($signed(held)), e); end
  endtask

  task automatic t_cfg_busy();
    int t;
    @(negedge clk);
    s_valid = 1'b1; s_data = 16'd777;
    @(negedge clk);
    s_valid = 1'b0;
    cfg_we = 1'b1; cfg_ladder = 1'b0; cfg_addr = '0; cfg_data = 16'h7000;
    @(negedge clk);
    cfg_ladder = 1'b1; cfg_addr = AW'(N); cfg_data = 16'h9000;
    t = 0;
    while (!m_valid && t < 200) begin @(negedge clk); t++; end
    @(negedge clk);
    cfg_we = 1'b0;
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
    begin longint e; model_step(777, e); end
    push_check("R8 busy write ignored", 4000);
    push_check("R8 busy write ignored", -4000);
  endtask

  task automatic t_addr_range();
    wr_coef(0, N, 20000, 0);
    wr_coef(1, (1 << AW) - 1, -20000, 0);
    push_check("R10 out-of-range ignored", 9000);
    push_check("R10 out-of-range ignored", -100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    model_clear();
    t_reset_state();
    t_passthrough();
    t_random(30);
    t_backpressure();
    t_cfg_busy();
    t_addr_range();
    t_stage_sat();
    t_out_sat();
    t_floor();
    // R1: state cleared by reset, same stream replays identically
    t_reset_state();
    wr_coef(1, N, 20000, 1);
    wr_coef(1, 1, -9000, 1);
    wr_coef(0, 2, 15000, 1);
    for (int s = 0; s < 4; s++) push_check("R1 zero state after reset", 5000 - s * 3000);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule